// File: doc/BRIEF.md
# Flash Row Self-Programming Controller

This block lets a processor rewrite its own program flash. Software aims a 21-bit table pointer at a flash byte and moves single bytes through table operations. A read copies the addressed flash byte into an output latch. A write drops the byte into an eight-byte staging buffer. Each operation can leave the pointer alone, step it after the access, step it back after the access, or step it forward before the access.

Committing the buffer, or wiping a 64-byte block, is a guarded action. The stored enable bit must already be on. The key register must then receive the two key bytes back to back, and the very next write must be a control write that raises the start bit. While the flash port works on the request, the controller holds the processor stalled and ignores every register and table request. Completion comes back from the flash as a one-cycle done pulse.

Top module: `flash_selfprog`

## Requirements
- R1: Register selects 0, 1 and 2 write bits 7:0, 15:8 and 20:16 of the pointer. Select 2 keeps only the five low data bits. The pointer resets to 0.
- R2: Table mode 0 keeps the pointer, 1 steps it up after the access, 2 steps it down after the access and 3 steps it up before the access. The access address is the pointer, or pointer+1 in mode 3. A table read shows the flash byte at that address on `tbl_latch` after the next clock edge.
- R3: A table write stores its byte in buffer slot (access address mod 8). A program start (control bit 1 = 0) sends all eight slots as one 64-bit word, with slot i in bits 8i+7:8i, to the row address equal to the pointer with bits 2:0 cleared.
- R4: An erase start (control bit 1 = 1) sends the pointer with bits 5:0 cleared as the block address, and that 64-byte block then reads 0xFF.
- R5: A control write (select 3) with bit 2 set is accepted only when the enable bit (bit 0) is already stored and the two preceding writes were 0x55 and then 0xAA to the key register (select 4). A start that is not accepted launches nothing and sets `key_err`.
- R6: Any other register write or table write after 0x55, or between 0xAA and the start, cancels the key sequence. A fresh 0x55 begins a new sequence.
- R7: An enable bit set in the start write itself does not count toward acceptance.
- R8: `cpu_stall` rises one cycle after an accepted start and falls one cycle after `fl_done`. `fl_req` is a one-cycle pulse. While stalled, including the cycle in which done arrives, register writes and table operations have no effect.
- R9: After each program commit every buffer slot reads 0xFF. Slots that were not loaded are sent as 0xFF and so leave their flash bytes unchanged.
- R10: An accepted start consumes the key sequence, so the next start needs both keys again. An accepted start clears `key_err`.
- R11: The pointer wraps modulo 2^21 in both directions.
- R12: When a pointer byte write and a table operation arrive in the same cycle, the written byte sets the pointer and the table step is dropped. The table access itself still uses the old pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 ptr low, 1 ptr high, 2 ptr top, 3 control, 4 key |
| reg_wdata | input | 8 | Register write data |
| tbl_go | input | 1 | Table operation strobe |
| tbl_write | input | 1 | 1 = table write, 0 = table read |
| tbl_mode | input | 2 | Pointer mode of the table operation |
| tbl_wdata | input | 8 | Byte for a table write |
| tbl_latch | output | 8 | Last byte fetched by a table read |
| tbl_ptr | output | 21 | Current table pointer |
| wr_enable | output | 1 | Stored enable bit |
| erase_mode | output | 1 | Stored erase-select bit |
| key_err | output | 1 | Rejected-start flag |
| cpu_stall | output | 1 | Processor stall, high while an operation runs |
| fl_req | output | 1 | One-cycle operation request to flash |
| fl_erase | output | 1 | 1 = block erase, 0 = row program |
| fl_row_addr | output | 21 | Aligned target address |
| fl_wdata | output | 64 | Row data for a program |
| fl_done | input | 1 | One-cycle completion pulse from flash |
| fl_raddr | output | 21 | Flash read address for table reads |
| fl_rdata | input | 8 | Flash read data |

## Verification
Two events can land in the same cycle. The first pair is flash completion and a fresh processor request: the bench holds a pointer write and a table write active for the whole stall, including the done cycle. It then requires the pointer to keep its old value and the committed row to show none of the poked data. The second pair is a pointer byte write and a table write issued together. That case is judged by the resulting pointer value and by the slot the byte reaches once the row is programmed and read back.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam logic [2:0] SEL_PLO  = 3'd0;
  localparam logic [2:0] SEL_PHI  = 3'd1;
  localparam logic [2:0] SEL_PUP  = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_KEY  = 3'd4;

  localparam int CB_WREN  = 0;
  localparam int CB_ERASE = 1;
  localparam int CB_START = 2;

  typedef enum logic [1:0] {
    TM_HOLD    = 2'd0,
    TM_POSTINC = 2'd1,
    TM_POSTDEC = 2'd2,
    TM_PREINC  = 2'd3
  } tmode_e;

  typedef enum logic [1:0] {
    UK_IDLE  = 2'd0,
    UK_HALF  = 2'd1,
    UK_ARMED = 2'd2
  } ukey_e;
endpackage

// File: rtl/fsp_tblptr.sv
module fsp_tblptr
  import fsp_pkg::*;
#(
  parameter int PTR_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_byte_en,
  input  logic [1:0]       byte_sel,
  input  logic [7:0]       byte_val,
  input  logic             step_en,
  input  logic [1:0]       mode,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] eff_addr
);
  localparam int UP_W = PTR_W - 16;

  logic [PTR_W-1:0] plus1, minus1, nxt;

  assign plus1    = ptr + PTR_W'(1);
  assign minus1   = ptr - PTR_W'(1);
  assign eff_addr = (tmode_e'(mode) == TM_PREINC) ? plus1 : ptr;

  always_comb begin
    nxt = ptr;
    if (wr_byte_en) begin
      case (byte_sel)
        2'd0:    nxt[7:0]        = byte_val;
        2'd1:    nxt[15:8]       = byte_val;
        default: nxt[PTR_W-1:16] = byte_val[UP_W-1:0];
      endcase
    end else if (step_en) begin
      case (tmode_e'(mode))
        TM_HOLD:    nxt = ptr;
        TM_POSTINC: nxt = plus1;
        TM_POSTDEC: nxt = minus1;
        TM_PREINC:  nxt = plus1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else     ptr <= nxt;
  end
endmodule

// File: rtl/fsp_holdbuf.sv
module fsp_holdbuf #(
  parameter int BYTES = 8,
  parameter int AW    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [7:0]         wdata,
  input  logic               clr,
  output logic [8*BYTES-1:0] row
);
  logic [7:0] slot [BYTES];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < BYTES; i++) slot[i] <= 8'hFF;
    end else if (we) begin
      slot[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_row
    assign row[8*g +: 8] = slot[g];
  end
endmodule

// File: rtl/fsp_unlock.sv
module fsp_unlock
  import fsp_pkg::*;
#(
  parameter logic [7:0] KEY1 = 8'h55,
  parameter logic [7:0] KEY2 = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [2:0] reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic       tbl_wr,
  input  logic       wren,
  output logic       start_ok,
  output logic       start_bad,
  output logic       armed
);
  ukey_e st, st_nx;
  logic  is_key, is_start;

  assign is_key    = reg_we && (reg_sel == SEL_KEY);
  assign is_start  = reg_we && (reg_sel == SEL_CTRL) && reg_wdata[CB_START];
  assign armed     = (st == UK_ARMED);
  assign start_ok  = is_start && armed && wren;
  assign start_bad = is_start && !(armed && wren);

  always_comb begin
    st_nx = st;
    if (is_key && reg_wdata == KEY1)                       st_nx = UK_HALF;
    else if (is_key && reg_wdata == KEY2 && st == UK_HALF) st_nx = UK_ARMED;
    else if (reg_we || tbl_wr)                             st_nx = UK_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= UK_IDLE;
    else     st <= st_nx;
  end

  // R10
  rekey_chk: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> !armed);
endmodule

// File: rtl/flash_selfprog.sv
module flash_selfprog
  import fsp_pkg::*;
#(
  parameter int         PTR_W       = 21,
  parameter int         BUF_BYTES   = 8,
  parameter int         ERASE_BYTES = 64,
  parameter logic [7:0] KEY1        = 8'h55,
  parameter logic [7:0] KEY2        = 8'hAA
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic [2:0]             reg_sel,
  input  logic [7:0]             reg_wdata,
  input  logic                   tbl_go,
  input  logic                   tbl_write,
  input  logic [1:0]             tbl_mode,
  input  logic [7:0]             tbl_wdata,
  output logic [7:0]             tbl_latch,
  output logic [PTR_W-1:0]       tbl_ptr,
  output logic                   wr_enable,
  output logic                   erase_mode,
  output logic                   key_err,
  output logic                   cpu_stall,
  output logic                   fl_req,
  output logic                   fl_erase,
  output logic [PTR_W-1:0]       fl_row_addr,
  output logic [8*BUF_BYTES-1:0] fl_wdata,
  input  logic                   fl_done,
  output logic [PTR_W-1:0]       fl_raddr,
  input  logic [7:0]             fl_rdata
);
  localparam int BUF_AW   = $clog2(BUF_BYTES);
  localparam int ERASE_AW = $clog2(ERASE_BYTES);
  localparam logic [PTR_W-1:0] PROG_MASK  = {{(PTR_W-BUF_AW){1'b1}}, {BUF_AW{1'b0}}};
  localparam logic [PTR_W-1:0] ERASE_MASK = {{(PTR_W-ERASE_AW){1'b1}}, {ERASE_AW{1'b0}}};

  logic             live, rw, tstep, ptr_wr, ctrl_wr, tbl_wr_ev, commit_clr;
  logic             start_ok, start_bad, armed;
  logic [PTR_W-1:0] eff_addr;

  assign live       = !cpu_stall;
  assign rw         = reg_we && live;
  assign tstep      = tbl_go && live;
  assign ptr_wr     = rw && (reg_sel <= SEL_PUP);
  assign ctrl_wr    = rw && (reg_sel == SEL_CTRL);
  assign tbl_wr_ev  = tstep && tbl_write;
  assign commit_clr = cpu_stall && fl_done && !fl_erase;
  assign fl_raddr   = eff_addr;

  fsp_tblptr #(.PTR_W(PTR_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .wr_byte_en(ptr_wr),
    .byte_sel  (reg_sel[1:0]),
    .byte_val  (reg_wdata),
    .step_en   (tstep),
    .mode      (tbl_mode),
    .ptr       (tbl_ptr),
    .eff_addr  (eff_addr)
  );

  fsp_holdbuf #(.BYTES(BUF_BYTES), .AW(BUF_AW)) u_buf (
    .clk  (clk),
    .rst  (rst),
    .we   (tbl_wr_ev),
    .waddr(eff_addr[BUF_AW-1:0]),
    .wdata(tbl_wdata),
    .clr  (commit_clr),
    .row  (fl_wdata)
  );

  fsp_unlock #(.KEY1(KEY1), .KEY2(KEY2)) u_key (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (rw),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .tbl_wr   (tbl_wr_ev),
    .wren     (wr_enable),
    .start_ok (start_ok),
    .start_bad(start_bad),
    .armed    (armed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_enable   <= 1'b0;
      erase_mode  <= 1'b0;
      key_err     <= 1'b0;
      cpu_stall   <= 1'b0;
      fl_req      <= 1'b0;
      fl_erase    <= 1'b0;
      fl_row_addr <= '0;
      tbl_latch   <= '0;
    end else begin
      fl_req <= start_ok;
      if (ctrl_wr) begin
        wr_enable  <= reg_wdata[CB_WREN];
        erase_mode <= reg_wdata[CB_ERASE];
      end
      if (start_bad)     key_err <= 1'b1;
      else if (start_ok) key_err <= 1'b0;
      if (start_ok) begin
        cpu_stall   <= 1'b1;
        fl_erase    <= reg_wdata[CB_ERASE];
        fl_row_addr <= tbl_ptr & (reg_wdata[CB_ERASE] ? ERASE_MASK : PROG_MASK);
      end else if (cpu_stall && fl_done) begin
        cpu_stall <= 1'b0;
      end
      if (tstep && !tbl_write) tbl_latch <= fl_rdata;
    end
  end

  // R5
  bad_start_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && reg_wdata[CB_START] && !armed |=> key_err && !fl_req);
  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fl_req |=> !fl_req);
  // R8
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    fl_req |-> cpu_stall);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_stall && !fl_done |=> cpu_stall);
  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_stall && fl_done |=> !cpu_stall);
endmodule

// File: tb/test_flash_selfprog.sv
`timescale 1ns/1ps
module test_flash_selfprog;
  import fsp_pkg::*;

  localparam int LAT = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we, tbl_go, tbl_write, fl_done;
  logic [2:0]  reg_sel;
  logic [7:0]  reg_wdata, tbl_wdata, tbl_latch, fl_rdata;
  logic [1:0]  tbl_mode;
  logic [20:0] tbl_ptr, fl_row_addr, fl_raddr;
  logic        wr_enable, erase_mode, key_err, cpu_stall, fl_req, fl_erase;
  logic [63:0] fl_wdata;

  always #4 clk = ~clk;

  flash_selfprog i_flash_selfprog (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .tbl_go(tbl_go), .tbl_write(tbl_write), .tbl_mode(tbl_mode), .tbl_wdata(tbl_wdata),
    .tbl_latch(tbl_latch), .tbl_ptr(tbl_ptr), .wr_enable(wr_enable), .erase_mode(erase_mode),
    .key_err(key_err), .cpu_stall(cpu_stall), .fl_req(fl_req), .fl_erase(fl_erase),
    .fl_row_addr(fl_row_addr), .fl_wdata(fl_wdata), .fl_done(fl_done),
    .fl_raddr(fl_raddr), .fl_rdata(fl_rdata)
  );

  // flash model: 256 bytes, fixed latency, erase sets 0xFF, program ANDs
  logic [7:0]  fmem [256];
  int          cnt;
  logic        er_l;
  logic [20:0] ad_l;
  logic [63:0] wd_l;

  assign fl_rdata = fmem[fl_raddr[7:0]];

  always @(posedge clk) begin
    fl_done <= 1'b0;
    if (rst) begin
      cnt <= 0;
      for (int a = 0; a < 256; a++) fmem[a] <= 8'(a) ^ 8'h3C;
    end else if (fl_req) begin
      cnt <= LAT; er_l <= fl_erase; ad_l <= fl_row_addr; wd_l <= fl_wdata;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        fl_done <= 1'b1;
        if (er_l) for (int i = 0; i < 64; i++) fmem[ad_l[7:0] + 8'(i)] <= 8'hFF;
        else for (int i = 0; i < 8; i++)
          fmem[ad_l[7:0] + 8'(i)] <= fmem[ad_l[7:0] + 8'(i)] & wd_l[8*i +: 8];
      end
    end
  end

  int          n_chk = 0, n_bad = 0;
  logic        finished = 1'b0;
  logic [7:0]  em [256];
  logic [7:0]  pb [8];
  logic [20:0] bp;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic rw(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic set_ptr(input logic [20:0] a);
    rw(SEL_PLO, a[7:0]); rw(SEL_PHI, a[15:8]); rw(SEL_PUP, {3'b0, a[20:16]});
    bp = a;
  endtask

  task automatic tbl_do(input logic w, input logic [1:0] m, input logic [7:0] d, output logic [7:0] expd);
    logic [20:0] a;
    a = (m == 2'd3) ? bp + 21'd1 : bp;
    expd = em[a[7:0]];
    if (w) pb[a[2:0]] = d;
    if (m == 2'd1 || m == 2'd3) bp = bp + 21'd1;
    else if (m == 2'd2) bp = bp - 21'd1;
    @(negedge clk); tbl_go = 1'b1; tbl_write = w; tbl_mode = m; tbl_wdata = d;
    @(negedge clk); tbl_go = 1'b0;
  endtask

  task automatic run_op(input logic er, input logic poke, output int nc);
    rw(SEL_CTRL, 8'h01); rw(SEL_KEY, 8'h55); rw(SEL_KEY, 8'hAA);
    rw(SEL_CTRL, {5'b0, 1'b1, er, 1'b1});
    nc = 0;
    if (poke) begin
      reg_we = 1'b1; reg_sel = SEL_PLO; reg_wdata = 8'h99;
      tbl_go = 1'b1; tbl_write = 1'b1; tbl_mode = 2'd1; tbl_wdata = 8'h00;
    end
    while (cpu_stall && nc < 1000) begin nc++; @(negedge clk); end
    reg_we = 1'b0; tbl_go = 1'b0;
  endtask

  task automatic do_prog(input logic poke, output int nc);
    logic [7:0] row;
    row = {bp[7:3], 3'b0};
    run_op(1'b0, poke, nc);
    for (int i = 0; i < 8; i++) begin
      em[row + 8'(i)] = em[row + 8'(i)] & pb[i];
      pb[i] = 8'hFF;
    end
  endtask

  task automatic do_erase(output int nc);
    logic [7:0] row;
    row = {bp[7:6], 6'b0};
    run_op(1'b1, 1'b0, nc);
    for (int i = 0; i < 64; i++) em[row + 8'(i)] = 8'hFF;
  endtask

  task automatic rdchk(input string rq, input logic [20:0] from, input int n);
    logic [7:0] e;
    set_ptr(from);
    for (int i = 0; i < n; i++) begin
      tbl_do(1'b0, 2'd1, 8'h00, e);
      chk(rq, "readback", tbl_latch, e);
    end
  endtask

  task automatic expect_reject(input string rq);
    chk(rq, "key_err", key_err, 1);
    chk(rq, "stall", cpu_stall, 0);
    chk(rq, "fl_req", fl_req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] e;
    int nc;
    reg_we = 0; reg_sel = 0; reg_wdata = 0; tbl_go = 0; tbl_write = 0; tbl_mode = 0; tbl_wdata = 0;
    rst = 1'b1; bp = '0;
    for (int a = 0; a < 256; a++) em[a] = 8'(a) ^ 8'h3C;
    for (int i = 0; i < 8; i++) pb[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R1", "reset ptr", tbl_ptr, 0);
    chk("R8", "reset stall", cpu_stall, 0);
    chk("R8", "reset req", fl_req, 0);
    chk("R5", "reset err", key_err, 0);

    // R1 pointer byte writes
    set_ptr(21'h1ABCDE);
    chk("R1", "ptr compose", tbl_ptr, 21'h1ABCDE);
    rw(SEL_PUP, 8'hFF); bp[20:16] = 5'h1F;
    chk("R1", "top byte 5 bits", tbl_ptr, 21'h1FBCDE);

    // R2 mode sweep
    for (int b = 0; b < 3; b++) begin
      set_ptr(b == 0 ? 21'h10 : (b == 1 ? 21'h55 : 21'hA3));
      for (int m = 0; m < 4; m++) begin
        for (int r = 0; r < 2; r++) begin
          tbl_do(1'b0, 2'(m), 8'h00, e);
          chk("R2", "read data", tbl_latch, e);
          chk("R2", "ptr after", tbl_ptr, bp);
        end
      end
    end

    // R11 wrap
    set_ptr(21'h1FFFFF);
    tbl_do(1'b0, 2'd1, 8'h00, e);
    chk("R11", "inc wrap", tbl_ptr, 0);
    tbl_do(1'b0, 2'd2, 8'h00, e);
    chk("R11", "dec wrap", tbl_ptr, 21'h1FFFFF);
    tbl_do(1'b0, 2'd3, 8'h00, e);
    chk("R11", "preinc wrap data", tbl_latch, e);
    chk("R11", "preinc wrap ptr", tbl_ptr, 0);

    // R5 start without keys
    rw(SEL_CTRL, 8'h01); rw(SEL_CTRL, 8'h05);
    expect_reject("R5");

    // R6 repeated first key still arms, R10 clears error
    set_ptr(21'hC5);
    rw(SEL_CTRL, 8'h01); rw(SEL_KEY, 8'h55); rw(SEL_KEY, 8'h55); rw(SEL_KEY, 8'hAA);
    rw(SEL_CTRL, 8'h07);
    chk("R6", "restart accepted", cpu_stall, 1);
    chk("R10", "err cleared", key_err, 0);
    while (cpu_stall) @(negedge clk);
    for (int i = 0; i < 64; i++) em[8'hC0 + 8'(i)] = 8'hFF;
    rdchk("R4", 21'hBC, 8);

    // R6 interruptions
    rw(SEL_KEY, 8'h55); rw(SEL_PLO, 8'hC5); rw(SEL_KEY, 8'hAA); rw(SEL_CTRL, 8'h07);
    expect_reject("R6");
    rw(SEL_KEY, 8'h55); tbl_do(1'b1, 2'd0, 8'hFF, e); rw(SEL_KEY, 8'hAA); rw(SEL_CTRL, 8'h07);
    expect_reject("R6");
    rw(SEL_KEY, 8'h55); rw(SEL_KEY, 8'hAA); tbl_do(1'b1, 2'd0, 8'hFF, e); rw(SEL_CTRL, 8'h07);
    expect_reject("R6");
    rw(SEL_KEY, 8'h55); rw(SEL_KEY, 8'hAA); rw(SEL_CTRL, 8'h01); rw(SEL_CTRL, 8'h07);
    expect_reject("R6");

    // R7 enable only in the start write
    rw(SEL_CTRL, 8'h00); rw(SEL_KEY, 8'h55); rw(SEL_KEY, 8'hAA); rw(SEL_CTRL, 8'h05);
    expect_reject("R7");
    chk("R7", "enable stored", wr_enable, 1);

    // R4 erase with unaligned pointer, R8 stall length
    set_ptr(21'h57);
    do_erase(nc);
    chk("R8", "stall cycles erase", nc, LAT + 2);
    chk("R10", "err clear after op", key_err, 0);
    rdchk("R4", 21'h38, 80);

    // R3 program via pre-increment fill, pointer mid-row
    set_ptr(21'h47);
    for (int i = 0; i < 8; i++) tbl_do(1'b1, 2'd3, 8'(i * 37 + 5), e);
    set_ptr(21'h4B);
    do_prog(1'b0, nc);
    rdchk("R3", 21'h40, 24);

    // R3 reprogram non-erased row (AND); R8 poke through the whole stall
    set_ptr(21'h48);
    for (int i = 0; i < 8; i++) tbl_do(1'b1, 2'd1, ~8'(i * 19), e);
    set_ptr(21'h4F);
    do_prog(1'b1, nc);
    chk("R8", "stall cycles poked", nc, LAT + 2);
    chk("R8", "ptr ignored while stalled", tbl_ptr, 21'h4F);
    rdchk("R3", 21'h48, 8);

    // R9 partial load, then empty commit
    set_ptr(21'h62); tbl_do(1'b1, 2'd0, 8'h5A, e);
    set_ptr(21'h65); tbl_do(1'b1, 2'd0, 8'hC3, e);
    set_ptr(21'h60);
    do_prog(1'b0, nc);
    rdchk("R9", 21'h60, 8);
    set_ptr(21'h60);
    do_prog(1'b0, nc);
    rdchk("R9", 21'h60, 8);

    // R10 keys consumed by the previous start
    rw(SEL_CTRL, 8'h05);
    chk("R10", "no rekey rejected", key_err, 1);
    chk("R10", "no rekey stall", cpu_stall, 0);

    // R12 simultaneous pointer write and table write
    set_ptr(21'h68);
    @(negedge clk);
    tbl_go = 1'b1; tbl_write = 1'b1; tbl_mode = 2'd1; tbl_wdata = 8'h3C;
    reg_we = 1'b1; reg_sel = SEL_PLO; reg_wdata = 8'h6E;
    @(negedge clk);
    tbl_go = 1'b0; reg_we = 1'b0;
    pb[0] = 8'h3C; bp = 21'h6E;
    chk("R12", "ptr from register", tbl_ptr, 21'h6E);
    do_prog(1'b0, nc);
    rdchk("R12", 21'h68, 8);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule